// File: doc/BRIEF.md
# I2C Command Sequencer (Single Master)

This block is a single-master I2C bus engine that software or a DMA engine steers with 3-bit command codes. A command write starts one bus operation: a start condition, a stop condition, one transmitted byte, one received byte, or a run of bytes paced by DMA requests. An undefined command code clears the error flags. The engine does not run from a free bit clock. It steps on a one-cycle tick that comes from an external prescaler, and each bit uses four ticks.

In the two DMA modes, an internal byte counter is loaded from `dma_cnt_i` when the command is accepted. The engine then moves that many bytes one at a time. Each byte is requested or announced by a single-cycle strobe, so the CPU does not take part until the run ends. Each of the two bus lines has its own drive-style input. One setting emulates open drain: the output is held low and only the enable toggles. The other drives the line both high and low.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, `busy_o`, both error flags and both DMA strobes are 0, and both lines sit at level high (in open-drain style `sda_oe_o`=0 and `scl_oe_o`=0).
- R2: Command 3'b001 makes SDA fall while SCL is high, then lowers SCL. It finishes on its 4th tick with both lines low.
- R3: Command 3'b010 raises SCL while SDA is low, then raises SDA. It finishes on its 4th tick with both lines high.
- R4: Command 3'b100 sends `tx_data_i` MSB first in 9 SCL pulses of 4 ticks each (36 ticks) and releases SDA in the 9th pulse. If SDA is sampled high in that 9th pulse, `err_nack_o` is set.
- R5: Command 3'b011 samples 8 bits MSB first into `rx_data_o` and drives SDA low (acknowledge) in the 9th pulse. It takes 36 ticks.
- R6: Codes 3'b000 and 3'b111 clear both error flags. They cause no bus activity, and `busy_o` stays 0.
- R7: A command written while busy is ignored, and it sets `err_ovr_o`. The running operation completes unchanged.
- R8: `busy_o` rises in the cycle after a command is accepted. It falls after the clock edge of the operation's last tick.
- R9: Command 3'b101 loads the byte counter. For each byte it pulses `dma_wreq_o` for one cycle, waits for `dma_wack_i` (which latches `tx_data_i`) and sends that byte. It ends after the counted bytes, or at once after a missing acknowledge.
- R10: Command 3'b110 receives the counted number of bytes. It pulses `dma_rreq_o` for one cycle on the same edge that updates `rx_data_o`. It acknowledges every byte except the last, which gets SDA high.
- R11: A DMA command with a count of 0 makes no bus activity and no request, and `busy_o` stays 0.
- R12: With a line's push-pull bit at 0, the output value is 0 and the enable is 1 only for level low. With the bit at 1, the enable is 1 and the output equals the level.
- R13: During byte transfers, SDA changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaler tick, one cycle wide |
| cmd_wr_i | input | 1 | Command write strobe |
| cmd_i | input | 3 | Command code |
| tx_data_i | input | DW | Byte to send (CPU send or DMA write data) |
| dma_cnt_i | input | CW | Byte count for the DMA modes |
| dma_wack_i | input | 1 | DMA write strobe answering a write request |
| sda_pp_i | input | 1 | SDA drive style, 1 = push-pull |
| scl_pp_i | input | 1 | SCL drive style, 1 = push-pull |
| sda_in_i | input | 1 | Sensed SDA bus level |
| rx_data_o | output | DW | Last received byte |
| busy_o | output | 1 | Operation in progress |
| err_nack_o | output | 1 | Missing acknowledge flag |
| err_ovr_o | output | 1 | Command-while-busy flag |
| dma_wreq_o | output | 1 | DMA write request strobe |
| dma_rreq_o | output | 1 | DMA read request strobe |
| sda_out_o | output | 1 | SDA output value |
| sda_oe_o | output | 1 | SDA output enable |
| scl_out_o | output | 1 | SCL output value |
| scl_oe_o | output | 1 | SCL output enable |

## Verification
A command is taken on the edge after the write strobe, so `busy_o` is checked at the next falling clock edge. The bench counts the ticks that are present while busy and expects 4 for a start or stop and 36 per byte. DMA strobes and `rx_data_o` are sampled at the falling edge that follows their updating edge, even when that same edge drops `busy_o`. Inputs change only at falling edges, and the tick changes just after rising edges. Bus levels are judged only once the operation has finished.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

  localparam logic [2:0] CMD_START = 3'b001;
  localparam logic [2:0] CMD_STOP  = 3'b010;
  localparam logic [2:0] CMD_RECV  = 3'b011;
  localparam logic [2:0] CMD_SEND  = 3'b100;
  localparam logic [2:0] CMD_DSEND = 3'b101;
  localparam logic [2:0] CMD_DRECV = 3'b110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_STOP,
    ST_BYTE,
    ST_WREQ
  } seq_state_e;

endpackage

// File: rtl/i2c_pin_drv.sv
module i2c_pin_drv #(
  parameter int NPIN = 2
) (
  input  logic [NPIN-1:0] lvl_i,
  input  logic [NPIN-1:0] pp_i,
  output logic [NPIN-1:0] out_o,
  output logic [NPIN-1:0] oe_o
);

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    always_comb begin
      if (pp_i[g]) begin
        out_o[g] = lvl_i[g];
        oe_o[g]  = 1'b1;
      end else begin
        out_o[g] = 1'b0;
        oe_o[g]  = ~lvl_i[g];
      end
    end
  end

endmodule

// File: rtl/i2c_byte_cnt.sv
module i2c_byte_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_i,
  input  logic [CW-1:0] val_i,
  input  logic          dec_i,
  output logic          last_o
);

  logic [CW-1:0] rem_q;
  logic [CW-1:0] rem_d;
  logic          rem_en;

  always_comb begin
    rem_en = ld_i | dec_i;
    rem_d  = ld_i ? val_i : (rem_q - CW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (rem_en) begin
      rem_q <= rem_d;
    end
  end

  assign last_o = (rem_q == CW'(1));

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !ld_i) |-> (rem_q != '0)); // R9

endmodule

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
  import i2c_cmd_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          cmd_wr_i,
  input  logic [2:0]    cmd_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic [CW-1:0] cnt_val_i,
  input  logic          cnt_last_i,
  input  logic          dma_wack_i,
  input  logic          sda_in_i,
  output logic          cnt_ld_o,
  output logic          cnt_dec_o,
  output logic          scl_lvl_o,
  output logic          sda_lvl_o,
  output logic [DW-1:0] rx_data_o,
  output logic          busy_o,
  output logic          err_nack_o,
  output logic          err_ovr_o,
  output logic          dma_wreq_o,
  output logic          dma_rreq_o
);

  localparam int BW = $clog2(DW + 1);
  localparam logic [BW-1:0] ACK_IDX = BW'(DW);

  seq_state_e    state_q, state_d;
  logic [1:0]    ph_q, ph_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [DW-1:0] sh_q, sh_d;
  logic [DW-1:0] rxd_q, rxd_d;
  logic          rx_q, rx_d;
  logic          dma_q, dma_d;
  logic          scl_q, scl_d;
  logic          sda_q, sda_d;
  logic          nack_q, nack_d;
  logic          ovr_q, ovr_d;
  logic          miss_q, miss_d;
  logic          wreq_q, wreq_d;
  logic          rreq_q, rreq_d;
  logic          is_ack;
  logic          ack_lvl;

  always_comb begin
    state_d   = state_q;
    ph_d      = ph_q;
    bit_d     = bit_q;
    sh_d      = sh_q;
    rxd_d     = rxd_q;
    rx_d      = rx_q;
    dma_d     = dma_q;
    scl_d     = scl_q;
    sda_d     = sda_q;
    nack_d    = nack_q;
    ovr_d     = ovr_q;
    miss_d    = miss_q;
    wreq_d    = 1'b0;
    rreq_d    = 1'b0;
    cnt_ld_o  = 1'b0;
    cnt_dec_o = 1'b0;
    is_ack    = (bit_q == ACK_IDX);
    ack_lvl   = dma_q & cnt_last_i;

    if (cmd_wr_i && (state_q != ST_IDLE)) begin
      ovr_d = 1'b1;
    end

    unique case (state_q)
      ST_IDLE: begin
        if (cmd_wr_i) begin
          ph_d   = 2'd0;
          bit_d  = '0;
          miss_d = 1'b0;
          case (cmd_i)
            CMD_START: state_d = ST_START;
            CMD_STOP:  state_d = ST_STOP;
            CMD_RECV: begin
              state_d = ST_BYTE;
              rx_d    = 1'b1;
              dma_d   = 1'b0;
            end
            CMD_SEND: begin
              state_d = ST_BYTE;
              rx_d    = 1'b0;
              dma_d   = 1'b0;
              sh_d    = tx_data_i;
            end
            CMD_DSEND: begin
              cnt_ld_o = 1'b1;
              if (cnt_val_i != '0) begin
                state_d = ST_WREQ;
                wreq_d  = 1'b1;
                rx_d    = 1'b0;
                dma_d   = 1'b1;
              end
            end
            CMD_DRECV: begin
              cnt_ld_o = 1'b1;
              if (cnt_val_i != '0) begin
                state_d = ST_BYTE;
                rx_d    = 1'b1;
                dma_d   = 1'b1;
              end
            end
            default: begin
              nack_d = 1'b0;
              ovr_d  = 1'b0;
            end
          endcase
        end
      end

      ST_WREQ: begin
        if (dma_wack_i) begin
          sh_d    = tx_data_i;
          state_d = ST_BYTE;
          ph_d    = 2'd0;
          bit_d   = '0;
        end
      end

      ST_START: begin
        if (tick_i) begin
          ph_d = ph_q + 2'd1;
          case (ph_q)
            2'd0:    sda_d = 1'b1;
            2'd1:    scl_d = 1'b1;
            2'd2:    sda_d = 1'b0;
            default: begin
              scl_d   = 1'b0;
              state_d = ST_IDLE;
            end
          endcase
        end
      end

      ST_STOP: begin
        if (tick_i) begin
          ph_d = ph_q + 2'd1;
          case (ph_q)
            2'd0:    sda_d = 1'b0;
            2'd1:    scl_d = 1'b1;
            2'd2:    sda_d = 1'b1;
            default: state_d = ST_IDLE;
          endcase
        end
      end

      ST_BYTE: begin
        if (tick_i) begin
          ph_d = ph_q + 2'd1;
          case (ph_q)
            2'd0: begin
              if (is_ack) sda_d = rx_q ? ack_lvl : 1'b1;
              else        sda_d = rx_q ? 1'b1 : sh_q[DW-1];
            end
            2'd1: scl_d = 1'b1;
            2'd2: begin
              if (is_ack) begin
                if (!rx_q && sda_in_i) begin
                  miss_d = 1'b1;
                  nack_d = 1'b1;
                end
              end else begin
                sh_d = {sh_q[DW-2:0], sda_in_i};
              end
            end
            default: begin
              scl_d = 1'b0;
              if (is_ack) begin
                bit_d = '0;
                if (rx_q) begin
                  rxd_d  = sh_q;
                  rreq_d = dma_q;
                end
                cnt_dec_o = dma_q;
                if (dma_q && !cnt_last_i && !miss_q) begin
                  if (!rx_q) begin
                    state_d = ST_WREQ;
                    wreq_d  = 1'b1;
                  end
                end else begin
                  state_d = ST_IDLE;
                end
              end else begin
                bit_d = bit_q + BW'(1);
              end
            end
          endcase
        end
      end

      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= 2'd0;
      bit_q   <= '0;
      sh_q    <= '0;
      rx_q    <= 1'b0;
      dma_q   <= 1'b0;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      nack_q  <= 1'b0;
      ovr_q   <= 1'b0;
      miss_q  <= 1'b0;
      wreq_q  <= 1'b0;
      rreq_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      rx_q    <= rx_d;
      dma_q   <= dma_d;
      scl_q   <= scl_d;
      sda_q   <= sda_d;
      nack_q  <= nack_d;
      ovr_q   <= ovr_d;
      miss_q  <= miss_d;
      wreq_q  <= wreq_d;
      rreq_q  <= rreq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_q <= '0;
    end else if (rreq_d || (rx_q && tick_i && is_ack && (ph_q == 2'd3))) begin
      rxd_q <= rxd_d;
    end
  end

  assign scl_lvl_o  = scl_q;
  assign sda_lvl_o  = sda_q;
  assign rx_data_o  = rxd_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign err_nack_o = nack_q;
  assign err_ovr_o  = ovr_q;
  assign dma_wreq_o = wreq_q;
  assign dma_rreq_o = rreq_q;

  AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_i && busy_o) |=> err_ovr_o); // R7

  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BYTE && scl_q && $past(scl_q)) |-> $stable(sda_q)); // R13

  AST_RREQ_DMA_RX: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rreq_o |-> (dma_q && rx_q)); // R10

  AST_WREQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_wreq_o |=> !dma_wreq_o); // R9

  AST_SCL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(scl_q)); // R4

endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2c_cmd_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          cmd_wr_i,
  input  logic [2:0]    cmd_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic [CW-1:0] dma_cnt_i,
  input  logic          dma_wack_i,
  input  logic          sda_pp_i,
  input  logic          scl_pp_i,
  input  logic          sda_in_i,
  output logic [DW-1:0] rx_data_o,
  output logic          busy_o,
  output logic          err_nack_o,
  output logic          err_ovr_o,
  output logic          dma_wreq_o,
  output logic          dma_rreq_o,
  output logic          sda_out_o,
  output logic          sda_oe_o,
  output logic          scl_out_o,
  output logic          scl_oe_o
);

  localparam int NPIN = 2;

  logic [1:0]      rs_q;
  logic            rst_s;
  logic            cnt_ld, cnt_dec, cnt_last;
  logic            scl_lvl, sda_lvl;
  logic [NPIN-1:0] pin_out, pin_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_s = rs_q[1];

  i2c_seq_fsm #(.DW(DW), .CW(CW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_s),
    .tick_i     (tick_i),
    .cmd_wr_i   (cmd_wr_i),
    .cmd_i      (cmd_i),
    .tx_data_i  (tx_data_i),
    .cnt_val_i  (dma_cnt_i),
    .cnt_last_i (cnt_last),
    .dma_wack_i (dma_wack_i),
    .sda_in_i   (sda_in_i),
    .cnt_ld_o   (cnt_ld),
    .cnt_dec_o  (cnt_dec),
    .scl_lvl_o  (scl_lvl),
    .sda_lvl_o  (sda_lvl),
    .rx_data_o  (rx_data_o),
    .busy_o     (busy_o),
    .err_nack_o (err_nack_o),
    .err_ovr_o  (err_ovr_o),
    .dma_wreq_o (dma_wreq_o),
    .dma_rreq_o (dma_rreq_o)
  );

  i2c_byte_cnt #(.CW(CW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_s),
    .ld_i   (cnt_ld),
    .val_i  (dma_cnt_i),
    .dec_i  (cnt_dec),
    .last_o (cnt_last)
  );

  i2c_pin_drv #(.NPIN(NPIN)) u_pins (
    .lvl_i ({scl_lvl, sda_lvl}),
    .pp_i  ({scl_pp_i, sda_pp_i}),
    .out_o (pin_out),
    .oe_o  (pin_oe)
  );

  assign sda_out_o = pin_out[0];
  assign sda_oe_o  = pin_oe[0];
  assign scl_out_o = pin_out[1];
  assign scl_oe_o  = pin_oe[1];

endmodule

// File: tb/i2c_cmd_master_test.sv
module i2c_cmd_master_test;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int GUARD      = 20000;

  // {cmd[2:0], data[7:0], slave_ack, exp_nack, exp_byte[7:0]}
  localparam logic [20:0] VEC [4] = '{
    {3'b100, 8'hA5, 1'b1, 1'b0, 8'hA5},
    {3'b100, 8'h3C, 1'b0, 1'b1, 8'h3C},
    {3'b011, 8'h96, 1'b0, 1'b0, 8'h96},
    {3'b011, 8'h01, 1'b0, 1'b0, 8'h01}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       cmd_wr_i = 1'b0;
  logic [2:0] cmd_i = 3'b000;
  logic [7:0] tx_data_i = 8'h00;
  logic [7:0] dma_cnt_i = 8'h00;
  logic       dma_wack_i = 1'b0;
  logic       sda_pp_i = 1'b0;
  logic       scl_pp_i = 1'b0;
  logic       sda_in_i;
  logic [7:0] rx_data_o;
  logic       busy_o, err_nack_o, err_ovr_o, dma_wreq_o, dma_rreq_o;
  logic       sda_out_o, sda_oe_o, scl_out_o, scl_oe_o;

  // bench bus and slave model
  logic       slv_rx = 1'b0;
  logic       slv_ack = 1'b1;
  logic [7:0] slv_base = 8'h00;
  int         bitc = 0;
  int         byte_idx = 0;
  logic [7:0] slv_cur, slv_sh;
  logic       slv_sda, sda_bus, scl_bus;

  assign slv_cur = slv_base + 8'(byte_idx);
  assign slv_sh  = slv_cur << bitc;
  assign slv_sda = slv_rx ? ((bitc < 8) ? slv_sh[7] : 1'b1)
                          : ((bitc == 8) ? ~slv_ack : 1'b1);
  assign scl_bus = scl_oe_o ? scl_out_o : 1'b1;
  assign sda_bus = (sda_oe_o ? sda_out_o : 1'b1) & slv_sda;
  assign sda_in_i = sda_bus;

  int         tests = 0;
  int         fails = 0;
  int         rises = 0;
  int         viol = 0;
  int         tick_busy = 0;
  int         wreq_n = 0;
  int         rreq_n = 0;
  int         mism = 0;
  logic       chk_data = 1'b0;
  logic       start_seen = 1'b0;
  logic       stop_seen = 1'b0;
  logic       first_busy = 1'b0;
  logic [7:0] cap = 8'h00;
  logic [7:0] ack_hist = 8'hFF;
  logic [7:0] cap_hist [8];
  logic       scl_p = 1'b1;
  logic       sda_p = 1'b1;

  i2c_cmd_master uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cmd_wr_i(cmd_wr_i),
    .cmd_i(cmd_i), .tx_data_i(tx_data_i), .dma_cnt_i(dma_cnt_i),
    .dma_wack_i(dma_wack_i), .sda_pp_i(sda_pp_i), .scl_pp_i(scl_pp_i),
    .sda_in_i(sda_in_i), .rx_data_o(rx_data_o), .busy_o(busy_o),
    .err_nack_o(err_nack_o), .err_ovr_o(err_ovr_o),
    .dma_wreq_o(dma_wreq_o), .dma_rreq_o(dma_rreq_o),
    .sda_out_o(sda_out_o), .sda_oe_o(sda_oe_o),
    .scl_out_o(scl_out_o), .scl_oe_o(scl_oe_o)
  );

  initial forever #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    int tdiv;
    tdiv = 0;
    forever begin
      @(posedge clk);
      #1;
      tdiv++;
      tick_i = (tdiv % TICK_DIV) == 0;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (scl_bus && !scl_p) begin
        if (bitc < 8) cap = {cap[6:0], sda_bus};
        else          ack_hist = {ack_hist[6:0], sda_bus};
        rises++;
      end
      if (!scl_bus && scl_p) begin
        if (bitc == 8) begin
          cap_hist[byte_idx[2:0]] = cap;
          byte_idx++;
          bitc = 0;
        end else begin
          bitc++;
        end
      end
      if (scl_bus && scl_p && (sda_bus != sda_p)) begin
        if (chk_data) viol++;
        if (!sda_bus) start_seen = 1'b1;
        else          stop_seen = 1'b1;
      end
      scl_p = scl_bus;
      sda_p = sda_bus;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic logic [7:0] dtx(input int k);
    return 8'h40 + 8'(k * 3);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic prep();
    bitc = 0;
    byte_idx = 0;
    rises = 0;
    ack_hist = 8'hFF;
    start_seen = 1'b0;
    stop_seen = 1'b0;
  endtask

  task automatic issue(input logic [2:0] c);
    @(negedge clk);
    cmd_i = c;
    cmd_wr_i = 1'b1;
    @(negedge clk);
    cmd_wr_i = 1'b0;
    first_busy = busy_o;
  endtask

  task automatic wait_done();
    int guard;
    guard = 0;
    tick_busy = 0;
    wreq_n = 0;
    rreq_n = 0;
    mism = 0;
    while (1) begin
      if (dma_rreq_o) begin
        if (rx_data_o != slv_base + 8'(rreq_n)) mism++;
        rreq_n++;
      end
      if (dma_wack_i) dma_wack_i = 1'b0;
      if (dma_wreq_o) begin
        tx_data_i = dtx(wreq_n);
        dma_wack_i = 1'b1;
        wreq_n++;
      end
      if (!busy_o || guard > GUARD) break;
      if (tick_i) tick_busy++;
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic run(input logic [2:0] c);
    issue(c);
    wait_done();
  endtask

  initial begin
    logic [20:0] v;
    // R1 reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "busy", busy_o, 0);
    chk("R1", "errors", {err_nack_o, err_ovr_o}, 0);
    chk("R1", "requests", {dma_wreq_o, dma_rreq_o}, 0);
    chk("R1", "bus levels", {scl_bus, sda_bus}, 2'b11);
    chk("R12", "open-drain idle out/oe", {sda_out_o, sda_oe_o, scl_out_o, scl_oe_o}, 0);

    // R2 start
    prep();
    run(3'b001);
    chk("R8", "busy after accept", first_busy, 1);
    chk("R2", "ticks", tick_busy, 4);
    chk("R2", "sda fell with scl high", start_seen, 1);
    chk("R2", "end levels", {scl_bus, sda_bus}, 2'b00);

    // table of single-byte transfers (R4, R5)
    chk_data = 1'b1;
    for (int i = 0; i < 4; i++) begin
      string req;
      v = VEC[i];
      req = (v[20:18] == 3'b100) ? "R4" : "R5";
      run(3'b000);
      prep();
      slv_rx = (v[20:18] == 3'b011);
      slv_ack = v[9];
      slv_base = v[17:10];
      tx_data_i = v[17:10];
      run(v[20:18]);
      chk(req, "ticks", tick_busy, 36);
      chk(req, "scl pulses", rises, 9);
      chk(req, "nack flag", err_nack_o, v[8]);
      if (slv_rx) begin
        chk("R5", "rx byte", rx_data_o, v[7:0]);
        chk("R5", "master ack bit", ack_hist[0], 0);
      end else begin
        chk("R4", "sent byte", cap_hist[0], v[7:0]);
      end
    end

    // R7 overrun: stop written while busy is ignored
    run(3'b000);
    prep();
    slv_rx = 1'b0;
    slv_ack = 1'b1;
    tx_data_i = 8'hC7;
    issue(3'b100);
    repeat (10) @(negedge clk);
    cmd_i = 3'b010;
    cmd_wr_i = 1'b1;
    @(negedge clk);
    cmd_wr_i = 1'b0;
    wait_done();
    chk("R7", "overrun flag", err_ovr_o, 1);
    chk("R7", "byte still sent", cap_hist[0], 8'hC7);
    chk("R7", "stop not run, scl low", scl_bus, 0);

    // R12 push-pull: scl level low, sda level high (released after tx)
    sda_pp_i = 1'b1;
    scl_pp_i = 1'b1;
    @(negedge clk);
    chk("R12", "push-pull out/oe", {sda_out_o, sda_oe_o, scl_out_o, scl_oe_o}, 4'b1101);
    sda_pp_i = 1'b0;
    scl_pp_i = 1'b0;
    @(negedge clk);
    chk("R12", "open-drain out/oe", {sda_out_o, sda_oe_o, scl_out_o, scl_oe_o}, 4'b0001);

    // R6 code 111 clears overrun, no bus activity
    run(3'b111);
    chk("R6", "flags cleared", {err_nack_o, err_ovr_o}, 0);
    chk("R6", "no busy", first_busy, 0);
    chk("R6", "lines unchanged", {scl_bus, sda_bus}, 2'b01);

    // R9 DMA send of three bytes
    prep();
    slv_rx = 1'b0;
    slv_ack = 1'b1;
    dma_cnt_i = 8'd3;
    run(3'b101);
    chk("R9", "write requests", wreq_n, 3);
    chk("R9", "byte 0", cap_hist[0], dtx(0));
    chk("R9", "byte 1", cap_hist[1], dtx(1));
    chk("R9", "byte 2", cap_hist[2], dtx(2));
    chk("R9", "ticks", tick_busy >= 108, 1);

    // R10 DMA receive of three bytes
    prep();
    slv_rx = 1'b1;
    slv_base = 8'h5E;
    run(3'b110);
    chk("R10", "read requests", rreq_n, 3);
    chk("R10", "rx data at request", mism, 0);
    chk("R10", "ack ack nack", ack_hist[2:0], 3'b001);

    // R11 count zero
    prep();
    slv_rx = 1'b0;
    dma_cnt_i = 8'd0;
    run(3'b101);
    repeat (20) begin
      @(negedge clk);
      if (dma_wreq_o || busy_o) wreq_n++;
    end
    chk("R11", "no busy", first_busy, 0);
    chk("R11", "no request or activity", wreq_n + rises, 0);

    // R9 DMA send aborted by missing acknowledge
    run(3'b000);
    prep();
    slv_ack = 1'b0;
    dma_cnt_i = 8'd3;
    run(3'b101);
    chk("R9", "abort after one request", wreq_n, 1);
    chk("R9", "nack flag", err_nack_o, 1);

    // R3 stop
    chk_data = 1'b0;
    prep();
    run(3'b010);
    chk("R3", "ticks", tick_busy, 4);
    chk("R3", "sda rose with scl high", stop_seen, 1);
    chk("R3", "end levels", {scl_bus, sda_bus}, 2'b11);

    chk("R13", "sda changes while scl high", viol, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule